// File: doc/BRIEF.md
# Receive Event Interrupt and DMA Halt Controller

This block gathers the receive-side event pulses of an Ethernet MAC into sticky status bits. It merges them through a per-source enable mask into a single registered receive interrupt. It also holds a halt flag for the receive DMA engine. The flag is raised when the engine runs out of descriptors and lowered only by an explicit resume command from software.

The event inputs are single-cycle pulses: a flow-control frame was received, a DMA access got an error response, no descriptor is free, and the Length/Type field of an incoming frame has arrived. Software uses one register write port for two things. A write to the clear register clears status bits, write-one-to-clear. A write to the resume register releases the DMA halt. A control frame only counts while the MAC runs in full duplex.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset, `status_o`, `dma_halt_o` and `rx_irq_o` are all 0.
- R2: Status bit 0 (control frame) is set by `evt_ctrl_frame_i` only while `full_duplex_i` is 1. In half duplex the event leaves bit 0 unchanged.
- R3: `evt_bus_err_i` sets status bit 1 at the next clock edge.
- R4: `evt_len_type_i` sets status bit 3 at the next clock edge.
- R5: `evt_no_desc_i` sets status bit 2 and `dma_halt_o` at the next clock edge.
- R6: A write with `wr_addr_i`=0 clears each status bit whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R7: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: A write with `wr_addr_i`=1, whatever the data, clears `dma_halt_o`. Clearing status bit 2 alone leaves `dma_halt_o` at 1.
- R9: A resume write in the same cycle as `evt_no_desc_i` is ignored, and `dma_halt_o` stays 1.
- R10: `rx_irq_o` equals, one cycle later, the OR over all bits of `status_o & irq_en_i`.
- R11: `irq_en_i` has no effect on whether status bits set. It only gates their contribution to `rx_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | MAC runs in full duplex |
| evt_ctrl_frame_i | input | 1 | Pulse: flow-control frame received |
| evt_bus_err_i | input | 1 | Pulse: error response on a receive DMA access |
| evt_no_desc_i | input | 1 | Pulse: no receive descriptor available |
| evt_len_type_i | input | 1 | Pulse: Length/Type field received |
| irq_en_i | input | 4 | Per-source interrupt enable, same bit order as status |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: status clear register, 1: resume register |
| wr_data_i | input | 4 | Write data, one-to-clear mask for address 0 |
| status_o | output | 4 | Sticky status: 0 ctrl frame, 1 bus error, 2 no descriptor, 3 Length/Type |
| rx_irq_o | output | 1 | Registered combined receive interrupt |
| dma_halt_o | output | 1 | Receive DMA halted for lack of descriptors |

## Verification
Two pairs of functions can meet in one cycle. An event can coincide with a write-one-to-clear of its own bit, and a descriptor-unavailable event can coincide with a resume write. The bench builds both collisions on purpose and also reaches them in a random phase where events and writes are drawn each cycle. A behavioural model applies "event wins" to each collision and is compared with every output at every clock, so a wrong priority shows as a mismatch in the cycle after the collision.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int unsigned NUM_SRC = 4;

  typedef enum int unsigned {
    SRC_CTRL  = 0,
    SRC_BUS   = 1,
    SRC_NODSC = 2,
    SRC_LENTY = 3
  } src_e;

  localparam logic REG_CLEAR  = 1'b0;
  localparam logic REG_RESUME = 1'b1;
endpackage

// File: rtl/rx_stat_bit.sv
module rx_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rx_dma_halt.sv
module rx_dma_halt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic no_desc_i,
  input  logic resume_i,
  output logic halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_o <= 1'b0;
    else if (no_desc_i) halt_o <= 1'b1;
    else if (resume_i)  halt_o <= 1'b0;
  end
endmodule

// File: rtl/rx_irq_merge.sv
module rx_irq_merge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & en_i);
  end
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               full_duplex_i,
  input  logic               evt_ctrl_frame_i,
  input  logic               evt_bus_err_i,
  input  logic               evt_no_desc_i,
  input  logic               evt_len_type_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               rx_irq_o,
  output logic               dma_halt_o
);
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic               resume;

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_CTRL]  = evt_ctrl_frame_i & full_duplex_i;
    set_vec[SRC_BUS]   = evt_bus_err_i;
    set_vec[SRC_NODSC] = evt_no_desc_i;
    set_vec[SRC_LENTY] = evt_len_type_i;
  end

  assign clr_vec = (wr_en_i && wr_addr_i == REG_CLEAR) ? wr_data_i : '0;
  assign resume  = wr_en_i && wr_addr_i == REG_RESUME;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_stat
    rx_stat_bit i_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .q_o    (status_o[g])
    );
  end

  rx_dma_halt i_halt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .no_desc_i (evt_no_desc_i),
    .resume_i  (resume),
    .halt_o    (dma_halt_o)
  );

  rx_irq_merge #(.N(NUM_SRC)) i_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (status_o),
    .en_i   (irq_en_i),
    .irq_o  (rx_irq_o)
  );
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       full_duplex_i,
  input logic       evt_ctrl_frame_i,
  input logic       evt_bus_err_i,
  input logic       evt_no_desc_i,
  input logic       evt_len_type_i,
  input logic [3:0] irq_en_i,
  input logic       wr_en_i,
  input logic       wr_addr_i,
  input logic [3:0] wr_data_i,
  input logic [3:0] status_o,
  input logic       rx_irq_o,
  input logic       dma_halt_o
);
  assert_half_duplex_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && evt_ctrl_frame_i && !status_o[0]) |=> !status_o[0]);

  assert_bus_err_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_bus_err_i |=> status_o[1]);

  assert_no_desc_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_no_desc_i |=> (status_o[2] && dma_halt_o));

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i && wr_data_i[3] && !evt_len_type_i) |=> !status_o[3]);

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_len_type_i && wr_en_i && !wr_addr_i && wr_data_i[3]) |=> status_o[3]);

  assert_halt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_halt_o && !(wr_en_i && wr_addr_i)) |=> dma_halt_o);

  assert_irq_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rx_irq_o == $past(|(status_o & irq_en_i))));
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .full_duplex_i    (full_duplex_i),
  .evt_ctrl_frame_i (evt_ctrl_frame_i),
  .evt_bus_err_i    (evt_bus_err_i),
  .evt_no_desc_i    (evt_no_desc_i),
  .evt_len_type_i   (evt_len_type_i),
  .irq_en_i         (irq_en_i),
  .wr_en_i          (wr_en_i),
  .wr_addr_i        (wr_addr_i),
  .wr_data_i        (wr_data_i),
  .status_o         (status_o),
  .rx_irq_o         (rx_irq_o),
  .dma_halt_o       (dma_halt_o)
);

// File: tb/test_rx_irq_ctrl.sv
`timescale 1ns/1ps
module test_rx_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       full_duplex_i = 1'b0;
  logic       evt_ctrl_frame_i = 1'b0, evt_bus_err_i = 1'b0;
  logic       evt_no_desc_i = 1'b0, evt_len_type_i = 1'b0;
  logic [3:0] irq_en_i = '0;
  logic       wr_en_i = 1'b0, wr_addr_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic [3:0] status_o;
  logic       rx_irq_o, dma_halt_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  bit [3:0] m_stat = '0;
  bit       m_halt = 0;
  bit       m_irq  = 0;

  always #2 clk_i = ~clk_i;

  rx_irq_ctrl i_rx_irq_ctrl (.*);

  function automatic void check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic void compare(string req);
    check(req, "status_o",   status_o,   m_stat);
    check(req, "dma_halt_o", dma_halt_o, m_halt);
    check(req, "rx_irq_o",   rx_irq_o,   m_irq);
  endfunction

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit fd, input bit [3:0] ev, input bit [3:0] en,
                     input bit we, input bit wa, input bit [3:0] wd, input string req);
    full_duplex_i    = fd;
    evt_ctrl_frame_i = ev[0];
    evt_bus_err_i    = ev[1];
    evt_no_desc_i    = ev[2];
    evt_len_type_i   = ev[3];
    irq_en_i         = en;
    wr_en_i          = we;
    wr_addr_i        = wa;
    wr_data_i        = wd;
    @(posedge clk_i);
    m_irq = |(m_stat & en);
    for (int i = 0; i < 4; i++) begin
      bit set_b, clr_b;
      set_b = ev[i] && (i != 0 || fd);
      clr_b = we && !wa && wd[i];
      if (set_b)      m_stat[i] = 1'b1;
      else if (clr_b) m_stat[i] = 1'b0;
    end
    if (ev[2])          m_halt = 1'b1;
    else if (we && wa)  m_halt = 1'b0;
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic idle(input bit [3:0] en, input string req);
    cyc(1'b1, 4'b0, en, 1'b0, 1'b0, 4'b0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R2: half duplex control frame ignored, full duplex sets it
    cyc(1'b0, 4'b0001, 4'hF, 0, 0, 4'h0, "R2");
    idle(4'hF, "R2");
    cyc(1'b1, 4'b0001, 4'hF, 0, 0, 4'h0, "R2");
    idle(4'hF, "R10");
    cyc(1'b1, 4'b0, 4'hF, 1, 0, 4'h1, "R6");
    idle(4'hF, "R10");

    // R11: masked sources still set; R10 irq only when enabled
    cyc(1'b1, 4'b1010, 4'h0, 0, 0, 4'h0, "R3");
    idle(4'h0, "R11");
    idle(4'h0, "R11");
    idle(4'b1000, "R10");
    idle(4'b1000, "R4");
    // R6: clear only bit 1, bit 3 stays
    cyc(1'b1, 4'b0, 4'b0010, 1, 0, 4'b0010, "R6");
    idle(4'b0010, "R10");
    // R7: event and clear of same bit together
    cyc(1'b1, 4'b1000, 4'hF, 1, 0, 4'b1000, "R7");
    idle(4'hF, "R7");
    cyc(1'b1, 4'b0, 4'hF, 1, 0, 4'hF, "R6");
    idle(4'hF, "R10");

    // R5, R8: halt, status clear does not resume
    cyc(1'b1, 4'b0100, 4'b0100, 0, 0, 4'h0, "R5");
    idle(4'b0100, "R10");
    cyc(1'b1, 4'b0, 4'b0100, 1, 0, 4'b0100, "R8");
    idle(4'b0100, "R8");
    // R9: resume with event in same cycle
    cyc(1'b1, 4'b0100, 4'b0100, 1, 1, 4'h0, "R9");
    idle(4'b0100, "R9");
    cyc(1'b1, 4'b0, 4'b0100, 1, 1, 4'h0, "R8");
    idle(4'b0100, "R8");
    // resume while not halted: no change
    cyc(1'b1, 4'b0, 4'b0100, 1, 1, 4'hF, "R8");
    cyc(1'b1, 4'b0, 4'b0100, 1, 0, 4'hF, "R6");

    // random collisions
    for (int k = 0; k < 400; k++) begin
      bit [3:0] ev;
      bit       we;
      ev = 4'($urandom) & 4'($urandom);
      we = 1'($urandom);
      cyc(1'($urandom), ev, 4'($urandom), we, 1'($urandom), 4'($urandom), "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule